// File: doc/BRIEF.md
# PLL Safe Reprogramming Sequencer

This block moves a clock synthesizer to a new set of divider coefficients (reference divider M, feedback divider N and post divider PL) without exposing the downstream logic to an abrupt frequency step. A single start pulse latches the new coefficients and the reference frequency in MHz. The sequencer then carries out the whole procedure on its own. It reads and writes the synthesizer's control registers over a simple request/acknowledge bus, and it asks an external ramp controller to glide the feedback divider whenever a smooth change is possible. A free-running one-microsecond tick paces every settling delay and the lock timeout.

When only N changes and the synthesizer is running, the whole job is one glide. Otherwise the sequencer takes the long route. It glides down to the lowest safe N, halves the output through a temporary 1:2 divider, switches the output to bypass, and brings the synthesizer out of power-down. It then disables it, writes the new coefficients, re-enables it, waits for lock, returns the output to the oscillator and glides up to the target N. If a glide or the lock wait fails, the whole procedure runs once more with gliding turned off. On its very first use the sequencer also puts the output-divider register into a known state.

Top module: `pll_reprog_seq`

## Requirements
- R1: If gliding is allowed, the new M equals coefficient bits 7:0, the new PL equals bits 23:16, and config bit 0 (enable) is 1, the operation is exactly one glide request to the new N and makes no bus write.
- R2: If gliding is allowed, the coefficients differ and config bit 0 is 1, a glide to ceil(oldM × VCO_MIN_MHZ / ref) is requested before any other bus write.
- R3: On the long route the sequencer first writes the output-divider register with bits 13:8 set to 2 and all other bits kept. At least SETTLE_US ticks after that write, it writes the select register with bit 0 cleared (bypass) and all other bits kept.
- R4: If config bit 1 (power-down) reads 1, the sequencer writes config with that bit cleared, reads it back and waits SETTLE_US ticks. Then, in every case, it writes config with bit 0 cleared.
- R5: The coefficient register is written as M in bits 7:0, N in 15:8, PL in 23:16 and zero in 31:24. N is ceil(newM × VCO_MIN_MHZ / ref) when gliding is allowed, and the new N when it is not.
- R6: Config is then written with bit 0 set. If bit 4 (lock-detect off) reads 1, config is written again with bit 4 cleared. Config is polled until bit 17 (lock) is 1. After LOCK_US ticks without lock the attempt fails. Bit 17 is never written as 1.
- R7: After lock the select register is written with bit 0 set. At least SETTLE_US ticks later, the output divider is written with bits 13:8 cleared. If gliding is allowed, a glide to the new N follows.
- R8: A failed glide or lock timeout during the gliding attempt restarts the sequence once with gliding disabled. The error flag is raised only if that retry also fails.
- R9: On the first start only, the output-divider register is rewritten with bit 31 = 1, bits 13:8 = 0 and bits 5:0 = 0x3C, with the other bits kept.
- R10: done is a one-cycle pulse per accepted start. err is updated together with done, holds until the next start, and both are 0 after reset.
- R11: A bus request holds its address, direction and write data until it is acknowledged.
- R12: A glide request holds its target N until the ramp controller reports completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a reprogramming operation (ignored while busy) |
| new_m | input | 8 | Target reference divider |
| new_n | input | 8 | Target feedback divider |
| new_pl | input | 8 | Target post-divider code |
| ref_mhz | input | 8 | Reference clock frequency in MHz |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Register address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| bus_ack | input | 1 | Access complete |
| slide_req | output | 1 | Glide request to the ramp controller |
| slide_n | output | 8 | Glide target N |
| slide_done | input | 1 | Glide finished (one cycle) |
| slide_err | input | 1 | Glide failed, valid with slide_done |
| done | output | 1 | Operation finished (one cycle) |
| err | output | 1 | Final attempt failed |

## Verification
The bench builds the sequencer with LOCK_US = 12 and SETTLE_US = 2 and pulses the tick every five clocks. A lock timeout therefore costs about sixty cycles, which brings the double failure (both attempts time out) and the recovery afterwards within a short run. VCO_MIN_MHZ stays at 1000. With the chosen M and reference values, the glide-down and start-up N values come out at non-trivial roundings (167, 250, 158, 84), so a floor-versus-ceiling slip shows up.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  localparam int DW = 32;
  localparam int FW = 8;

  localparam int CFG_EN_BIT   = 0;
  localparam int CFG_PD_BIT   = 1;
  localparam int CFG_LDO_BIT  = 4;
  localparam int CFG_LOCK_BIT = 17;
  localparam int SEL_VCO_BIT  = 0;
  localparam int VDIV_LSB     = 8;
  localparam int VDIV_W       = 6;
  localparam int BDIV_LSB     = 0;
  localparam int BDIV_W       = 6;
  localparam int POST_BIT     = 31;
  localparam logic [BDIV_W-1:0] BDIV_INIT = 6'h3C;

  typedef enum logic [4:0] {
    S_IDLE, S_INIT_RD, S_INIT_WR, S_COEF_RD, S_CFG_RD, S_SLIDE,
    S_DIV2_RD, S_DIV2_WR, S_BYP_RD, S_BYP_WAIT, S_BYP_WR,
    S_PD_RD, S_PD_WR, S_PD_BACK, S_PD_WAIT, S_DIS_WR, S_DIS_BACK,
    S_COEF_WR, S_EN_WR, S_EN_RD, S_LDO_WR, S_LOCK_RD,
    S_VCO_RD, S_VCO_WR, S_OUT_RD, S_OUT_WAIT, S_OUT_WR, S_FINISH
  } seq_state_e;

  // Lowest feedback divider that keeps the oscillator at or above vmin.
  function automatic logic [FW-1:0] low_ndiv(input logic [FW-1:0] m,
                                            input logic [FW-1:0] ref_mhz,
                                            input int unsigned vmin);
    int unsigned num;
    int unsigned q;
    if (ref_mhz == '0) return '1;
    num = int'(m) * vmin + int'(ref_mhz) - 1;
    q   = num / int'(ref_mhz);
    return q[FW-1:0];
  endfunction

  function automatic logic [DW-1:0] with_vdiv(input logic [DW-1:0] v,
                                             input logic [VDIV_W-1:0] d);
    logic [DW-1:0] r;
    r = v;
    r[VDIV_LSB +: VDIV_W] = d;
    return r;
  endfunction

  function automatic logic [DW-1:0] outdiv_boot(input logic [DW-1:0] v);
    logic [DW-1:0] r;
    r = with_vdiv(v, '0);
    r[POST_BIT] = 1'b1;
    r[BDIV_LSB +: BDIV_W] = BDIV_INIT;
    return r;
  endfunction

  function automatic logic [DW-1:0] coef_word(input logic [FW-1:0] m,
                                             input logic [FW-1:0] n,
                                             input logic [FW-1:0] pl);
    return {8'h00, pl, n, m};
  endfunction

  // Lock is a status bit: never write it back.
  function automatic logic [DW-1:0] cfg_put(input logic [DW-1:0] v,
                                           input int bitpos,
                                           input logic val);
    logic [DW-1:0] r;
    r = v;
    r[bitpos] = val;
    r[CFG_LOCK_BIT] = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/seq_tick_timer.sv
module seq_tick_timer #(
  parameter int TW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] val,
  input  logic          tick,
  output logic          expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (load)               cnt <= val;
    else if (tick && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R6
  expired_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !load) |=> expired);
endmodule

// File: rtl/seq_bus_port.sv
module seq_bus_port #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ack,
  output logic          fin
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else if (!bus_req && go) begin
      bus_req   <= 1'b1;
      bus_we    <= we;
      bus_addr  <= addr;
      bus_wdata <= wdata;
    end else if (bus_req && bus_ack) begin
      bus_req <= 1'b0;
    end
  end

  assign fin = bus_req && bus_ack;

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)
                               && $stable(bus_wdata)));
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
  import pll_seq_pkg::*;
#(
  parameter int          AW          = 16,
  parameter logic [AW-1:0] CFG_ADDR    = 'h0000,
  parameter logic [AW-1:0] COEF_ADDR   = 'h0004,
  parameter logic [AW-1:0] OUTDIV_ADDR = 'h0008,
  parameter logic [AW-1:0] VCOSEL_ADDR = 'h000C,
  parameter int          LOCK_US     = 300,
  parameter int          SETTLE_US   = 2,
  parameter int          VCO_MIN_MHZ = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    new_m,
  input  logic [7:0]    new_n,
  input  logic [7:0]    new_pl,
  input  logic [7:0]    ref_mhz,
  input  logic          us_tick,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [31:0]   bus_wdata,
  input  logic [31:0]   bus_rdata,
  input  logic          bus_ack,
  output logic          slide_req,
  output logic [7:0]    slide_n,
  input  logic          slide_done,
  input  logic          slide_err,
  output logic          done,
  output logic          err
);
  localparam int TW_L = $clog2(LOCK_US + 1);
  localparam int TW_S = $clog2(SETTLE_US + 1);
  localparam int TW   = (TW_L > TW_S) ? TW_L : TW_S;
  localparam logic [TW-1:0] T_LOCK   = TW'(LOCK_US);
  localparam logic [TW-1:0] T_SETTLE = TW'(SETTLE_US);

  seq_state_e st, st_d, ret_q, ret_d;
  logic allow_q, allow_d, init_q, init_d, fail_q, fail_d, err_q, err_d, done_q;
  logic [FW-1:0] m_q, m_d, n_q, n_d, pl_q, pl_d, ref_q, ref_d;
  logic [FW-1:0] om_q, om_d, opl_q, opl_d, tgt_q, tgt_d;
  logic [DW-1:0] rd_q;

  // Named events for the checks and the timer.
  logic op_act, op_we, bus_fin, t_load, t_exp, attempt_bad;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_wdata;
  logic [TW-1:0] t_val;

  seq_bus_port #(.AW(AW), .DW(DW)) u_bus (
    .clk(clk), .rst_n(rst_n), .go(op_act && !bus_req), .we(op_we),
    .addr(op_addr), .wdata(op_wdata), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack), .fin(bus_fin)
  );

  seq_tick_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(t_load), .val(t_val), .tick(us_tick),
    .expired(t_exp)
  );

  always_comb begin
    st_d = st;       ret_d = ret_q;   allow_d = allow_q; init_d = init_q;
    fail_d = fail_q; err_d = err_q;   m_d = m_q;  n_d = n_q; pl_d = pl_q;
    ref_d = ref_q;   om_d = om_q;     opl_d = opl_q; tgt_d = tgt_q;
    t_load = 1'b0;   t_val = '0;      attempt_bad = 1'b0;
    op_act = 1'b0;   op_we = 1'b0;    op_addr = CFG_ADDR; op_wdata = '0;
    case (st)
      S_IDLE: if (start) begin
        m_d = new_m; n_d = new_n; pl_d = new_pl; ref_d = ref_mhz;
        allow_d = 1'b1; fail_d = 1'b0; err_d = 1'b0;
        st_d = init_q ? S_COEF_RD : S_INIT_RD;
      end
      S_INIT_RD: begin
        op_act = 1'b1; op_addr = OUTDIV_ADDR;
        if (bus_fin) st_d = S_INIT_WR;
      end
      S_INIT_WR: begin
        op_act = 1'b1; op_we = 1'b1; op_addr = OUTDIV_ADDR;
        op_wdata = outdiv_boot(rd_q);
        if (bus_fin) begin init_d = 1'b1; st_d = S_COEF_RD; end
      end
      S_COEF_RD: begin
        op_act = 1'b1; op_addr = COEF_ADDR;
        if (bus_fin) begin
          om_d = bus_rdata[7:0]; opl_d = bus_rdata[23:16]; st_d = S_CFG_RD;
        end
      end
      S_CFG_RD: begin
        op_act = 1'b1; op_addr = CFG_ADDR;
        if (bus_fin) begin
          if (allow_q && bus_rdata[CFG_EN_BIT] && m_q == om_q && pl_q == opl_q) begin
            tgt_d = n_q; ret_d = S_FINISH; st_d = S_SLIDE;
          end else if (allow_q && bus_rdata[CFG_EN_BIT]) begin
            tgt_d = low_ndiv(om_q, ref_q, VCO_MIN_MHZ); ret_d = S_DIV2_RD; st_d = S_SLIDE;
          end else begin
            st_d = S_DIV2_RD;
          end
        end
      end
      S_SLIDE: if (slide_done) begin
        if (slide_err) attempt_bad = 1'b1;
        else st_d = ret_q;
      end
      S_DIV2_RD: begin
        op_act = 1'b1; op_addr = OUTDIV_ADDR;
        if (bus_fin) st_d = S_DIV2_WR;
      end
      S_DIV2_WR: begin
        op_act = 1'b1; op_we = 1'b1; op_addr = OUTDIV_ADDR;
        op_wdata = with_vdiv(rd_q, 6'd2);
        if (bus_fin) st_d = S_BYP_RD;
      end
      S_BYP_RD: begin
        op_act = 1'b1; op_addr = VCOSEL_ADDR;
        if (bus_fin) begin t_load = 1'b1; t_val = T_SETTLE; st_d = S_BYP_WAIT; end
      end
      S_BYP_WAIT: if (t_exp) st_d = S_BYP_WR;
      S_BYP_WR: begin
        op_act = 1'b1; op_we = 1'b1; op_addr = VCOSEL_ADDR;
        op_wdata = rd_q; op_wdata[SEL_VCO_BIT] = 1'b0;
        if (bus_fin) st_d = S_PD_RD;
      end
      S_PD_RD: begin
        op_act = 1'b1; op_addr = CFG_ADDR;
        if (bus_fin) st_d = bus_rdata[CFG_PD_BIT] ? S_PD_WR : S_DIS_WR;
      end
      S_PD_WR: begin
        op_act = 1'b1; op_we = 1'b1; op_wdata = cfg_put(rd_q, CFG_PD_BIT, 1'b0);
        if (bus_fin) st_d = S_PD_BACK;
      end
      S_PD_BACK: begin
        op_act = 1'b1;
        if (bus_fin) begin t_load = 1'b1; t_val = T_SETTLE; st_d = S_PD_WAIT; end
      end
      S_PD_WAIT: if (t_exp) st_d = S_DIS_WR;
      S_DIS_WR: begin
        op_act = 1'b1; op_we = 1'b1; op_wdata = cfg_put(rd_q, CFG_EN_BIT, 1'b0);
        if (bus_fin) st_d = S_DIS_BACK;
      end
      S_DIS_BACK: begin
        op_act = 1'b1;
        if (bus_fin) st_d = S_COEF_WR;
      end
      S_COEF_WR: begin
        op_act = 1'b1; op_we = 1'b1; op_addr = COEF_ADDR;
        op_wdata = coef_word(m_q, allow_q ? low_ndiv(m_q, ref_q, VCO_MIN_MHZ) : n_q, pl_q);
        if (bus_fin) st_d = S_EN_WR;
      end
      S_EN_WR: begin
        op_act = 1'b1; op_we = 1'b1; op_wdata = cfg_put(rd_q, CFG_EN_BIT, 1'b1);
        if (bus_fin) st_d = S_EN_RD;
      end
      S_EN_RD: begin
        op_act = 1'b1;
        if (bus_fin) begin
          if (bus_rdata[CFG_LDO_BIT]) st_d = S_LDO_WR;
          else begin t_load = 1'b1; t_val = T_LOCK; st_d = S_LOCK_RD; end
        end
      end
      S_LDO_WR: begin
        op_act = 1'b1; op_we = 1'b1; op_wdata = cfg_put(rd_q, CFG_LDO_BIT, 1'b0);
        if (bus_fin) begin t_load = 1'b1; t_val = T_LOCK; st_d = S_LOCK_RD; end
      end
      S_LOCK_RD: begin
        op_act = 1'b1;
        if (bus_fin) begin
          if (bus_rdata[CFG_LOCK_BIT]) st_d = S_VCO_RD;
          else if (t_exp) attempt_bad = 1'b1;
        end
      end
      S_VCO_RD: begin
        op_act = 1'b1; op_addr = VCOSEL_ADDR;
        if (bus_fin) st_d = S_VCO_WR;
      end
      S_VCO_WR: begin
        op_act = 1'b1; op_we = 1'b1; op_addr = VCOSEL_ADDR;
        op_wdata = rd_q; op_wdata[SEL_VCO_BIT] = 1'b1;
        if (bus_fin) st_d = S_OUT_RD;
      end
      S_OUT_RD: begin
        op_act = 1'b1; op_addr = OUTDIV_ADDR;
        if (bus_fin) begin t_load = 1'b1; t_val = T_SETTLE; st_d = S_OUT_WAIT; end
      end
      S_OUT_WAIT: if (t_exp) st_d = S_OUT_WR;
      S_OUT_WR: begin
        op_act = 1'b1; op_we = 1'b1; op_addr = OUTDIV_ADDR;
        op_wdata = with_vdiv(rd_q, '0);
        if (bus_fin) begin
          if (allow_q) begin tgt_d = n_q; ret_d = S_FINISH; st_d = S_SLIDE; end
          else st_d = S_FINISH;
        end
      end
      S_FINISH: begin err_d = fail_q; st_d = S_IDLE; end
      default: st_d = S_IDLE;
    endcase
    if (attempt_bad) begin
      if (allow_q) begin allow_d = 1'b0; st_d = S_COEF_RD; end
      else begin fail_d = 1'b1; st_d = S_FINISH; end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ret_q <= S_IDLE; allow_q <= 1'b0; init_q <= 1'b0;
      fail_q <= 1'b0; err_q <= 1'b0; done_q <= 1'b0;
      m_q <= '0; n_q <= '0; pl_q <= '0; ref_q <= '0;
      om_q <= '0; opl_q <= '0; tgt_q <= '0; rd_q <= '0;
    end else begin
      st <= st_d; ret_q <= ret_d; allow_q <= allow_d; init_q <= init_d;
      fail_q <= fail_d; err_q <= err_d; done_q <= (st == S_FINISH);
      m_q <= m_d; n_q <= n_d; pl_q <= pl_d; ref_q <= ref_d;
      om_q <= om_d; opl_q <= opl_d; tgt_q <= tgt_d;
      if (bus_fin && !bus_we) rd_q <= bus_rdata;
    end
  end

  assign slide_req = (st == S_SLIDE);
  assign slide_n   = tgt_q;
  assign done      = done_q;
  assign err       = err_q;

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done);
  // R12
  slide_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slide_req && !slide_done) |=> (slide_req && $stable(slide_n)));
  // R6
  lock_never_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_addr == CFG_ADDR) |-> !bus_wdata[CFG_LOCK_BIT]);
  // R5
  coef_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_addr == COEF_ADDR) |-> (bus_wdata[31:24] == 8'h00));
endmodule

// File: tb/pll_reprog_seq_bench.sv
module pll_reprog_seq_bench;
  localparam int AW = 16;
  localparam logic [15:0] A_CFG = 16'h0000, A_COEF = 16'h0004,
                          A_OUT = 16'h0008, A_SEL = 16'h000C;
  localparam int LOCK_US = 12, SETTLE = 2, VMIN = 1000;

  logic clk = 0, rst_n = 0, start = 0, us_tick = 0;
  logic [7:0] new_m = 0, new_n = 0, new_pl = 0, ref_mhz = 0;
  logic bus_req, bus_we, bus_ack = 0, slide_req, slide_done = 0, slide_err = 0;
  logic done, err;
  logic [AW-1:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata = 0;
  logic [7:0] slide_n;

  pll_reprog_seq #(.AW(AW), .LOCK_US(LOCK_US), .SETTLE_US(SETTLE), .VCO_MIN_MHZ(VMIN)) u_pll_reprog_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .new_m(new_m), .new_n(new_n),
    .new_pl(new_pl), .ref_mhz(ref_mhz), .us_tick(us_tick), .bus_req(bus_req),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .slide_req(slide_req),
    .slide_n(slide_n), .slide_done(slide_done), .slide_err(slide_err),
    .done(done), .err(err));

  always #2 clk = ~clk;  // 250 MHz

  int n_chk = 0, n_fail = 0, tick_n = 0;
  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Register and ramp-controller model
  logic [31:0] r_cfg = 32'h0000_0012, r_coef = 0, r_out = 32'h1234_5678, r_sel = 32'h0000_00A0;
  bit m_lock = 1;
  int m_fail = 0, sl_cnt = 0;
  bit sl_busy = 0;
  always @(posedge clk) begin
    slide_done <= 1'b0;
    if (bus_req && !bus_ack) begin
      bus_ack <= 1'b1;
      if (bus_we) begin
        case (bus_addr)
          A_CFG: r_cfg <= bus_wdata;
          A_COEF: r_coef <= bus_wdata;
          A_OUT: r_out <= bus_wdata;
          default: r_sel <= bus_wdata;
        endcase
      end else begin
        case (bus_addr)
          A_CFG: bus_rdata <= r_cfg | ((m_lock && r_cfg[0]) ? 32'h0002_0000 : 32'h0);
          A_COEF: bus_rdata <= r_coef;
          A_OUT: bus_rdata <= r_out;
          default: bus_rdata <= r_sel;
        endcase
      end
    end else bus_ack <= 1'b0;
    if (slide_req && !slide_done && !sl_busy) begin
      sl_busy <= 1; sl_cnt <= 3;
    end else if (sl_busy) begin
      if (sl_cnt == 0) begin
        sl_busy <= 0; slide_done <= 1'b1;
        if (m_fail > 0) begin slide_err <= 1'b1; m_fail <= m_fail - 1; end
        else begin slide_err <= 1'b0; r_coef[15:8] <= slide_n; end
      end else sl_cnt <= sl_cnt - 1;
    end
    if (us_tick) tick_n <= tick_n + 1;
  end

  initial forever begin
    repeat (4) @(negedge clk);
    us_tick = 1; @(negedge clk); us_tick = 0;
  end

  // Scoreboard
  typedef struct { bit is_slide; logic [15:0] addr; logic [31:0] data; string tag; } ev_t;
  ev_t exp_q[$];
  logic [31:0] p_cfg = 32'h0000_0012, p_coef = 0, p_out = 32'h1234_5678, p_sel = 32'h0000_00A0;
  bit p_init = 0;

  task automatic push_w(input logic [15:0] a, input logic [31:0] d, input string tag);
    ev_t e; e.is_slide = 0; e.addr = a; e.data = d; e.tag = tag; exp_q.push_back(e);
  endtask
  task automatic push_s(input logic [7:0] n, input string tag);
    ev_t e; e.is_slide = 1; e.addr = 0; e.data = {24'h0, n}; e.tag = tag; exp_q.push_back(e);
  endtask
  function automatic logic [7:0] nlo(input int m, input int r);
    int v; v = (m * VMIN + r - 1) / r; return v[7:0];
  endfunction

  task automatic predict(input logic [7:0] m, n, pl, rf, input bit lk, input int fl, output bit e);
    bit al, ok;
    if (!p_init) begin
      p_out[31] = 1; p_out[13:8] = 0; p_out[5:0] = 6'h3C; push_w(A_OUT, p_out, "R9"); p_init = 1;
    end
    e = 1;
    for (int att = 0; att < 2 && e; att++) begin
      al = (att == 0); ok = 1;
      if (al && p_coef[7:0] == m && p_coef[23:16] == pl && p_cfg[0]) begin
        push_s(n, "R1");
        if (fl > 0) begin fl--; ok = 0; end else p_coef[15:8] = n;
      end else begin
        if (al && p_cfg[0]) begin
          push_s(nlo(p_coef[7:0], rf), "R2");
          if (fl > 0) begin fl--; ok = 0; end else p_coef[15:8] = nlo(p_coef[7:0], rf);
        end
        if (ok) begin
          p_out[13:8] = 2; push_w(A_OUT, p_out, "R3");
          p_sel[0] = 0; push_w(A_SEL, p_sel, "R3");
          if (p_cfg[1]) begin p_cfg[1] = 0; push_w(A_CFG, p_cfg, "R4"); end
          p_cfg[0] = 0; push_w(A_CFG, p_cfg, "R4");
          p_coef = {8'h0, pl, al ? nlo(m, rf) : n, m}; push_w(A_COEF, p_coef, "R5");
          p_cfg[0] = 1; push_w(A_CFG, p_cfg, "R6");
          if (p_cfg[4]) begin p_cfg[4] = 0; push_w(A_CFG, p_cfg, "R6"); end
          if (!lk) ok = 0;
          else begin
            p_sel[0] = 1; push_w(A_SEL, p_sel, "R7");
            p_out[13:8] = 0; push_w(A_OUT, p_out, "R7");
            if (al) begin
              push_s(n, "R7");
              if (fl > 0) begin fl--; ok = 0; end else p_coef[15:8] = n;
            end
          end
        end
      end
      e = !ok;
    end
  endtask

  // Monitor
  bit prev_req = 0, prev_ack = 0, prev_sreq = 0, prev_sdone = 0, sel_set = 0;
  logic [15:0] prev_addr = 0;
  int tk_div = 0, tk_sel = 0;
  always @(negedge clk) if (rst_n) begin
    if (prev_req && !prev_ack) chk(bus_req && bus_addr == prev_addr, "R11", {16'h0, bus_addr}, {16'h0, prev_addr});
    if (prev_sreq && !prev_sdone) chk(slide_req == 1'b1, "R12", {31'h0, slide_req}, 32'h1);
    if (bus_req && bus_ack && bus_we) begin
      if (exp_q.size() == 0) chk(0, "R1", bus_wdata, 32'h0);
      else begin
        ev_t e; e = exp_q.pop_front();
        chk(!e.is_slide && e.addr == bus_addr && e.data == bus_wdata, e.tag, bus_wdata, e.data);
      end
      if (bus_addr == A_SEL && !bus_wdata[0]) chk(tick_n - tk_div >= SETTLE, "R3", tick_n - tk_div, SETTLE);
      if (bus_addr == A_SEL && bus_wdata[0]) begin sel_set = 1; tk_sel = tick_n; end
      if (bus_addr == A_OUT) begin
        if (sel_set) chk(tick_n - tk_sel >= SETTLE, "R7", tick_n - tk_sel, SETTLE);
        sel_set = 0; tk_div = tick_n;
      end
    end
    if (slide_req && !prev_sreq) begin
      if (exp_q.size() == 0) chk(0, "R12", {24'h0, slide_n}, 32'h0);
      else begin
        ev_t e; e = exp_q.pop_front();
        chk(e.is_slide && e.data[7:0] == slide_n, e.tag, {24'h0, slide_n}, e.data);
      end
    end
    prev_req = bus_req; prev_ack = bus_ack; prev_addr = bus_addr;
    prev_sreq = slide_req; prev_sdone = slide_done;
  end

  task automatic run_op(input logic [7:0] m, n, pl, rf, input bit lk, input int fl, input string tag);
    bit e;
    m_lock = lk; m_fail = fl;
    predict(m, n, pl, rf, lk, fl, e);
    @(negedge clk);
    new_m = m; new_n = n; new_pl = pl; ref_mhz = rf; start = 1;
    @(negedge clk); start = 0;
    while (!done) @(negedge clk);
    chk(err == e, tag, {31'h0, err}, {31'h0, e});
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
    @(negedge clk);
    chk(!done, "R10", {31'h0, done}, 32'h0);
    chk(err == e, "R10", {31'h0, err}, {31'h0, e});
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R10 watchdog: actual no done expected done");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(!done && !err, "R10", {30'h0, done, err}, 32'h0);
    chk(!bus_req && !slide_req, "R11", {30'h0, bus_req, slide_req}, 32'h0);
    rst_n = 1;
    run_op(8'd2, 8'd100, 8'd1, 8'd12, 1, 0, "R9");   // first use, full path from power-down
    run_op(8'd2, 8'd120, 8'd1, 8'd12, 1, 0, "R1");   // glide only
    run_op(8'd3, 8'd90,  8'd2, 8'd12, 1, 0, "R2");   // glide down, reprogram, glide up
    run_op(8'd1, 8'd60,  8'd0, 8'd19, 1, 1, "R8");   // glide fails, retry without glide
    run_op(8'd2, 8'd80,  8'd1, 8'd12, 0, 0, "R6");   // lock never comes, both attempts fail
    run_op(8'd2, 8'd110, 8'd1, 8'd12, 1, 0, "R10");  // recovery clears the error
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule